// File: doc/BRIEF.md
# Motion Adaptive Line De-interlacer

This block turns an interlaced stream of 4:2:2 YCbCr samples into progressive video. Each input sample carries one luma value and its co-sited chroma value (Cb on even pixels, Cr on odd pixels), together with a field-parity bit, a line-start flag and a valid strobe. For each arriving line the block emits two progressive lines side by side on two output lanes. One lane carries the field line as received. The other lane carries the rebuilt missing line that sits next to it in the frame.

The missing line is a per-pixel mix of two candidates. The weave candidate is the co-sited sample of the most recent field of the opposite parity, which gives A,B,A,B line order on still content. The repeat candidate is the current sample itself, which gives A,A,B,B line order on moving content. The motion at each pixel is the absolute luma change against the same position one frame earlier (the last field of the same parity). Two thresholds map this change onto a 4-bit weight, and the weight moves the result smoothly from weave to repeat. Chroma uses the weight computed from its own pixel's luma.

Both field parities are held in internal memories. The line width and the number of lines per field are parameters, and both must be powers of two.

Top module: `motion_deinterlacer`

## Requirements
- R1: For a field of parity 0 the top lane carries the received line and the bottom lane carries the rebuilt line. For parity 1 the roles are swapped. The output field bit echoes the parity of the sample.
- R2: The lane that carries the received line reproduces each input Y and C value unchanged.
- R3: When the motion measure d = |Y - Y one frame earlier| is at or below thr_lo, the weight k is 0 and the rebuilt sample equals the co-sited sample of the last opposite-parity field (weave).
- R4: When d is at or above thr_hi (with thr_hi > thr_lo), k is 15 and the rebuilt sample is ((16-k)*weave + k*repeat + 8) >> 4 with k = 15.
- R5: When thr_lo < d < thr_hi, k = floor((d - thr_lo) * 15 / (thr_hi - thr_lo)), and the rebuilt sample is ((16-k)*weave + k*current + 8) >> 4.
- R6: The rebuilt chroma value uses the same k as the luma of its pixel and the same blend formula.
- R7: Until a field of the same parity has been completed (a parity change has closed it), k is forced to 15. Until a field of the opposite parity has been completed, the weave candidate is replaced by the current sample.
- R8: Each valid input sample produces exactly one output sample, three clock cycles later and in the same order. out_sol marks the first pixel of each line. out_valid is low when no sample is due.
- R9: During reset and right after it, out_valid is low.
- R10: When thr_hi <= thr_lo, k is 0 for d <= thr_lo and 15 for any larger d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_sol | input | 1 | First pixel of a line (valid with in_valid) |
| in_field | input | 1 | Field parity of the sample |
| in_y | input | 8 | Luma |
| in_c | input | 8 | Co-sited chroma (Cb on even pixels, Cr on odd pixels) |
| thr_lo | input | 8 | Motion level at or below which the pixel counts as still |
| thr_hi | input | 8 | Motion level at or above which the pixel counts as fully moving |
| out_valid | output | 1 | Output sample strobe |
| out_sol | output | 1 | First pixel of an output line pair |
| out_field | output | 1 | Parity of the field the pair came from |
| out_top_y | output | 8 | Luma of the upper progressive line |
| out_top_c | output | 8 | Chroma of the upper progressive line |
| out_bot_y | output | 8 | Luma of the lower progressive line |
| out_bot_c | output | 8 | Chroma of the lower progressive line |

## Verification
The bench builds the block with LINE_W = 8 and FIELD_LINES = 4, so a full field is 32 samples. Five fields of alternating parity then fit in a few hundred cycles. This covers the start-up fields where motion is forced, steady weave and repeat, the thresholds exactly at both ends of the ramp, several points inside the ramp, and a change to a degenerate threshold pair.

// File: rtl/mdi_pkg.sv
// Shared types for the motion adaptive de-interlacer.
// Assumes 8-bit luma and 8-bit co-sited chroma per sample.
package mdi_pkg;

    typedef struct packed {
        logic [7:0] y;
        logic [7:0] c;
    } mdi_pix_t;

    localparam logic [3:0] MDI_K_FULL = 4'd15;

endpackage

// File: rtl/mdi_line_tracker.sv
// Tracks pixel and line position inside the current field, and which field
// parities have been completed since reset.
// Assumes in_sol arrives with in_valid on the first pixel of every line, and
// that a parity change only happens on a line start.
module mdi_line_tracker #(
    parameter int LINE_W      = 64,
    parameter int FIELD_LINES = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic                           in_sol,
    input  logic                           in_field,
    output logic [$clog2(FIELD_LINES)-1:0] line_idx,
    output logic [$clog2(LINE_W)-1:0]      pix_idx,
    output logic                           same_ok,
    output logic                           opp_ok
);
    localparam int PIX_AW  = $clog2(LINE_W);
    localparam int LINE_AW = $clog2(FIELD_LINES);

    logic               started;
    logic               cur_par;
    logic [1:0]         seen;
    logic [LINE_AW-1:0] line_cnt;
    logic [PIX_AW-1:0]  pix_cnt;
    logic               new_field;
    logic               closing;

    // Position of the arriving sample and availability of the stored fields.
    always_comb begin
        new_field = in_sol && (!started || (in_field != cur_par));
        closing   = new_field && started;
        pix_idx   = in_sol ? '0 : pix_cnt;
        if (!in_sol)
            line_idx = line_cnt;
        else if (new_field)
            line_idx = '0;
        else
            line_idx = line_cnt + 1'b1;
        same_ok = seen[in_field];
        opp_ok  = seen[~in_field] | closing;
    end

    // Advance the counters and mark a parity as complete when its field closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started  <= 1'b0;
            cur_par  <= 1'b0;
            seen     <= 2'b00;
            line_cnt <= '0;
            pix_cnt  <= '0;
        end else if (in_valid) begin
            pix_cnt <= pix_idx + 1'b1;
            if (in_sol) begin
                started  <= 1'b1;
                cur_par  <= in_field;
                line_cnt <= line_idx;
                if (closing)
                    seen[cur_par] <= 1'b1;
            end
        end
    end

    // R7
    seen_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && closing) |=> (seen[$past(cur_par)] == 1'b1));

endmodule

// File: rtl/mdi_field_store.sv
// Holds one field of each parity. A single write per cycle goes to the
// current parity; two synchronous reads return the same position one frame
// back (same parity, old value) and in the opposite parity.
// Assumes power-of-two LINE_W and FIELD_LINES. Contents are not reset.
module mdi_field_store
    import mdi_pkg::*;
#(
    parameter int LINE_W      = 64,
    parameter int FIELD_LINES = 8
) (
    input  logic                           clk,
    input  logic                           wr_en,
    input  logic                           wr_par,
    input  logic [$clog2(FIELD_LINES)-1:0] wr_line,
    input  logic [$clog2(LINE_W)-1:0]      wr_pix,
    input  mdi_pix_t                       wr_data,
    output logic [7:0]                     prev_y,
    output mdi_pix_t                       opp_q
);
    localparam int PIX_AW  = $clog2(LINE_W);
    localparam int LINE_AW = $clog2(FIELD_LINES);
    localparam int ADDR_W  = 1 + LINE_AW + PIX_AW;
    localparam int DEPTH   = 1 << ADDR_W;

    mdi_pix_t          mem [DEPTH];
    logic [ADDR_W-1:0] same_a;
    logic [ADDR_W-1:0] opp_a;

    // Addresses of the same-parity and opposite-parity entries.
    always_comb begin
        same_a = {wr_par, wr_line, wr_pix};
        opp_a  = {~wr_par, wr_line, wr_pix};
    end

    // Read both entries, then overwrite the same-parity one.
    always_ff @(posedge clk) begin
        prev_y <= mem[same_a].y;
        opp_q  <= mem[opp_a];
        if (wr_en)
            mem[same_a] <= wr_data;
    end

endmodule

// File: rtl/mdi_motion_map.sv
// Turns the per-pixel luma change against the previous frame into a 4-bit
// blend weight through a low/high threshold ramp, and registers it.
// Assumes force_full is asserted while no same-parity history exists.
module mdi_motion_map
    import mdi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd,
    input  logic [7:0] cur_y,
    input  logic [7:0] prev_y,
    input  logic       force_full,
    input  logic [7:0] thr_lo,
    input  logic [7:0] thr_hi,
    output logic [3:0] k_q
);
    logic [7:0]  diff;
    logic [7:0]  span;
    logic [7:0]  over;
    logic [11:0] scaled;
    logic [3:0]  k_c;

    // Absolute change and position on the threshold ramp.
    always_comb begin
        diff   = (cur_y >= prev_y) ? (cur_y - prev_y) : (prev_y - cur_y);
        span   = thr_hi - thr_lo;
        over   = diff - thr_lo;
        scaled = {4'b0000, over} * 12'd15;
        if (diff <= thr_lo)
            k_c = 4'd0;
        else if (diff >= thr_hi)
            k_c = MDI_K_FULL;
        else
            k_c = 4'(scaled / {4'b0000, span});
    end

    // Hold the weight for the blend stage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            k_q <= 4'd0;
        else if (upd)
            k_q <= force_full ? MDI_K_FULL : k_c;
    end

    // R7
    forced_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && force_full) |=> (k_q == MDI_K_FULL));

    // R3
    still_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !force_full && (diff <= thr_lo)) |=> (k_q == 4'd0));

    // R10
    step_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !force_full && (thr_hi <= thr_lo) && (diff > thr_lo)) |=> (k_q == MDI_K_FULL));

endmodule

// File: rtl/mdi_blend_lane.sv
// Mixes a weave candidate and a repeat candidate by weight k/16 with
// rounding. Purely combinational; one instance per colour channel.
module mdi_blend_lane (
    input  logic [7:0] weave,
    input  logic [7:0] rep,
    input  logic [3:0] k,
    output logic [7:0] res
);
    logic [4:0]  kw;
    logic [12:0] acc;

    // Weighted sum with half-step rounding.
    always_comb begin
        kw  = 5'd16 - {1'b0, k};
        acc = 13'(kw) * 13'(weave) + 13'(k) * 13'(rep) + 13'd8;
        res = 8'(acc >> 4);
    end

    // Bound and weave checks on the settled result.
    always_comb begin
        // R5
        bounded_mix_chk: assert (((weave <= rep) && (res >= weave) && (res <= rep)) ||
                                 ((weave > rep) && (res >= rep) && (res <= weave)));
        // R3
        zero_k_weave_chk: assert ((k != 4'd0) || (res == weave));
    end

endmodule

// File: rtl/motion_deinterlacer.sv
// Motion adaptive de-interlacer. Each input sample yields one received-line
// sample and one rebuilt-line sample on two lanes, three cycles later.
// Assumes power-of-two LINE_W and FIELD_LINES and in_sol on every line start.
module motion_deinterlacer
    import mdi_pkg::*;
#(
    parameter int LINE_W      = 64,
    parameter int FIELD_LINES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_sol,
    input  logic       in_field,
    input  logic [7:0] in_y,
    input  logic [7:0] in_c,
    input  logic [7:0] thr_lo,
    input  logic [7:0] thr_hi,
    output logic       out_valid,
    output logic       out_sol,
    output logic       out_field,
    output logic [7:0] out_top_y,
    output logic [7:0] out_top_c,
    output logic [7:0] out_bot_y,
    output logic [7:0] out_bot_c
);
    localparam int PIX_AW  = $clog2(LINE_W);
    localparam int LINE_AW = $clog2(FIELD_LINES);
    localparam int N_CH    = 2;

    logic [LINE_AW-1:0] line_idx;
    logic [PIX_AW-1:0]  pix_idx;
    logic               same_ok;
    logic               opp_ok;
    mdi_pix_t           in_pix;
    logic [7:0]         prev_y;
    mdi_pix_t           opp_q;

    logic               v1, sol1, f1, force1, oppok1;
    mdi_pix_t           cur1;
    mdi_pix_t           weave1;
    logic [3:0]         k_q;

    logic               v2, sol2, f2;
    mdi_pix_t           cur2;
    mdi_pix_t           weave2;

    logic [7:0]         w_ch [N_CH];
    logic [7:0]         r_ch [N_CH];
    logic [7:0]         m_ch [N_CH];

    assign in_pix = mdi_pix_t'({in_y, in_c});

    mdi_line_tracker #(
        .LINE_W      (LINE_W),
        .FIELD_LINES (FIELD_LINES)
    ) u_tracker (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sol   (in_sol),
        .in_field (in_field),
        .line_idx (line_idx),
        .pix_idx  (pix_idx),
        .same_ok  (same_ok),
        .opp_ok   (opp_ok)
    );

    mdi_field_store #(
        .LINE_W      (LINE_W),
        .FIELD_LINES (FIELD_LINES)
    ) u_store (
        .clk     (clk),
        .wr_en   (in_valid),
        .wr_par  (in_field),
        .wr_line (line_idx),
        .wr_pix  (pix_idx),
        .wr_data (in_pix),
        .prev_y  (prev_y),
        .opp_q   (opp_q)
    );

    // Stage 1: capture the sample alongside the memory reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1     <= 1'b0;
            sol1   <= 1'b0;
            f1     <= 1'b0;
            force1 <= 1'b1;
            oppok1 <= 1'b0;
            cur1   <= '0;
        end else begin
            v1     <= in_valid;
            sol1   <= in_valid && in_sol;
            f1     <= in_field;
            force1 <= !same_ok;
            oppok1 <= opp_ok;
            cur1   <= in_pix;
        end
    end

    // Weave candidate falls back to the current sample without history.
    always_comb weave1 = oppok1 ? opp_q : cur1;

    mdi_motion_map u_motion (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd        (v1),
        .cur_y      (cur1.y),
        .prev_y     (prev_y),
        .force_full (force1),
        .thr_lo     (thr_lo),
        .thr_hi     (thr_hi),
        .k_q        (k_q)
    );

    // Stage 2: carry the candidates level with the registered weight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2     <= 1'b0;
            sol2   <= 1'b0;
            f2     <= 1'b0;
            cur2   <= '0;
            weave2 <= '0;
        end else begin
            v2     <= v1;
            sol2   <= sol1;
            f2     <= f1;
            cur2   <= cur1;
            weave2 <= weave1;
        end
    end

    // Split both candidates per channel for the blend lanes.
    always_comb begin
        w_ch[0] = weave2.y;
        w_ch[1] = weave2.c;
        r_ch[0] = cur2.y;
        r_ch[1] = cur2.c;
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_lane
        mdi_blend_lane u_lane (
            .weave (w_ch[g]),
            .rep   (r_ch[g]),
            .k     (k_q),
            .res   (m_ch[g])
        );
    end

    // Stage 3: place received and rebuilt lines on the lanes by parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sol   <= 1'b0;
            out_field <= 1'b0;
            out_top_y <= '0;
            out_top_c <= '0;
            out_bot_y <= '0;
            out_bot_c <= '0;
        end else begin
            out_valid <= v2;
            out_sol   <= sol2;
            out_field <= f2;
            if (!f2) begin
                out_top_y <= cur2.y;
                out_top_c <= cur2.c;
                out_bot_y <= m_ch[0];
                out_bot_c <= m_ch[1];
            end else begin
                out_top_y <= m_ch[0];
                out_top_c <= m_ch[1];
                out_bot_y <= cur2.y;
                out_bot_c <= cur2.c;
            end
        end
    end

    // Cycles since reset, so latency checks look back only into valid history.
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (!rst_n)
            warm <= 2'd0;
        else if (warm != 2'd3)
            warm <= warm + 2'd1;
    end

    // R8
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R8
    sol_in_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sol |-> out_valid);

    // R2
    orig_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm == 2'd3) && out_valid) |->
        ((out_field ? {out_bot_y, out_bot_c} : {out_top_y, out_top_c}) ==
         {$past(in_y, 3), $past(in_c, 3)}));

    // R1
    field_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm == 2'd3) && out_valid) |-> (out_field == $past(in_field, 3)));

endmodule

// File: tb/motion_deinterlacer_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver computes each expected output pair from the
// requirements and queues it; the monitor pops and compares on output.
module motion_deinterlacer_bench;
    localparam int LW = 8;
    localparam int FL = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_sol = 1'b0;
    logic       in_field = 1'b0;
    logic [7:0] in_y = '0;
    logic [7:0] in_c = '0;
    logic [7:0] thr_lo = 8'd8;
    logic [7:0] thr_hi = 8'd40;
    logic       out_valid, out_sol, out_field;
    logic [7:0] out_top_y, out_top_c, out_bot_y, out_bot_c;

    always #2 clk = ~clk;

    motion_deinterlacer #(.LINE_W(LW), .FIELD_LINES(FL)) u_motion_deinterlacer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
        .in_field(in_field), .in_y(in_y), .in_c(in_c),
        .thr_lo(thr_lo), .thr_hi(thr_hi),
        .out_valid(out_valid), .out_sol(out_sol), .out_field(out_field),
        .out_top_y(out_top_y), .out_top_c(out_top_c),
        .out_bot_y(out_bot_y), .out_bot_c(out_bot_c)
    );

    typedef struct {
        int ty, tc, by, bc;
        bit sol, fld;
        int it;
    } exp_t;

    exp_t sbq[$];
    exp_t mon_e;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    int   my [2][FL][LW];
    int   mc [2][FL][LW];
    bit   have [2];
    bit   started = 1'b0;
    int   cpar = 0;

    function automatic string tname(int t);
        case (t)
            3:  return "R3";
            4:  return "R4";
            7:  return "R7";
            10: return "R10";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(bit ok, string tag, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int dl(int i);
        case (i)
            0: return 0;   1: return 5;   2: return 8;   3: return 9;
            4: return 20;  5: return 39;  6: return 40;  default: return 100;
        endcase
    endfunction

    function automatic int dm(int i);
        case (i)
            0: return 0;   1: return 19;  2: return 20;  3: return 21;
            4: return 50;  5: return 3;   6: return 25;  default: return 0;
        endcase
    endfunction

    function automatic int gen_y(int fi, int l, int p);
        case (fi)
            0: return 10 + 16 * l + 3 * p;
            1: return 200 - 7 * p - 11 * l;
            2: return gen_y(0, l, p) + dl((p + l) % 8);
            3: return gen_y(1, l, p) - dl(p);
            default: return gen_y(2, l, p) + dm(p);
        endcase
    endfunction

    function automatic int gen_c(int fi, int l, int p);
        return (gen_y(fi, l, p) * 3 + p + fi * 17) & 255;
    endfunction

    function automatic int kcalc(int d, int lo, int hi);
        if (d <= lo) return 0;
        if (d >= hi) return 15;
        return ((d - lo) * 15) / (hi - lo);
    endfunction

    function automatic int bl(int w, int r, int k);
        return ((16 - k) * w + k * r + 8) >> 4;
    endfunction

    // Drive one line and queue the expected output pair for each pixel.
    task automatic send_line(int par, int ln, int fi);
        if (!started || par != cpar) begin
            if (started) have[cpar] = 1'b1;
            cpar    = par;
            started = 1'b1;
        end
        for (int p = 0; p < LW; p++) begin
            exp_t e;
            int y, c, wy, wc, d, k, iy, ic;
            y  = gen_y(fi, ln, p);
            c  = gen_c(fi, ln, p);
            wy = have[1 - par] ? my[1 - par][ln][p] : y;
            wc = have[1 - par] ? mc[1 - par][ln][p] : c;
            d  = y - my[par][ln][p];
            if (d < 0) d = -d;
            k  = have[par] ? kcalc(d, int'(thr_lo), int'(thr_hi)) : 15;
            if (!have[par] || !have[1 - par]) e.it = 7;
            else if (thr_hi <= thr_lo)        e.it = 10;
            else if (k == 0)                  e.it = 3;
            else if (k == 15)                 e.it = 4;
            else                              e.it = 5;
            iy = bl(wy, y, k);
            ic = bl(wc, c, k);
            e.sol = (p == 0);
            e.fld = par[0];
            if (par == 0) begin
                e.ty = y;  e.tc = c;  e.by = iy; e.bc = ic;
            end else begin
                e.ty = iy; e.tc = ic; e.by = y;  e.bc = c;
            end
            sbq.push_back(e);
            my[par][ln][p] = y;
            mc[par][ln][p] = c;
            in_valid = 1'b1;
            in_sol   = (p == 0);
            in_field = par[0];
            in_y     = 8'(y);
            in_c     = 8'(c);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_sol   = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Monitor: pop one expected pair per output sample and compare lanes.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R8", 1, 0);
            end else begin
                mon_e = sbq.pop_front();
                chk(int'(out_top_y) == mon_e.ty, mon_e.fld ? tname(mon_e.it) : "R2", int'(out_top_y), mon_e.ty);
                chk(int'(out_top_c) == mon_e.tc, mon_e.fld ? "R6" : "R2", int'(out_top_c), mon_e.tc);
                chk(int'(out_bot_y) == mon_e.by, mon_e.fld ? "R2" : tname(mon_e.it), int'(out_bot_y), mon_e.by);
                chk(int'(out_bot_c) == mon_e.bc, mon_e.fld ? "R2" : "R6", int'(out_bot_c), mon_e.bc);
                chk(out_sol == mon_e.sol, "R8", int'(out_sol), int'(mon_e.sol));
                chk(out_field == mon_e.fld, "R1", int'(out_field), int'(mon_e.fld));
            end
        end
    end

    // Stimulus: five fields of alternating parity, then a degenerate ramp.
    initial begin
        have[0] = 1'b0;
        have[1] = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R9", int'(out_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0, "R9", int'(out_valid), 0);
        for (int f = 0; f < 4; f++)
            for (int l = 0; l < FL; l++)
                send_line(f % 2, l, f);
        thr_lo = 8'd20;
        thr_hi = 8'd20;
        for (int l = 0; l < FL; l++)
            send_line(0, l, 4);
        repeat (10) @(negedge clk);
        chk(sbq.size() == 0, "R8", sbq.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R8: watchdog, pending %0d expected 0", sbq.size());
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule